// File: doc/BRIEF.md
# Receive Link Realignment Controller

This block supervises dynamic phase alignment on a source-synchronous packet receive interface. It watches three signals from the receive datapath: an out-of-frame flag, a pulse for a parity (DIP-4) error, and a pulse for alignment-complete. From these it decides when to send a one-cycle alignment request to the phase-alignment logic. A phase sweep can only lock while the far end is sending training sequences. The far end starts training only after it sees the framing pattern on the FIFO status channel. For this reason the controller sends a request only while the receiver is out of frame, and only after a settle delay that gives the peer time to switch over.

The block drives the framing-pattern select for the status-channel serializer. While that select is high, the serializer sends binary 11 in every status slot. If no alignment-complete arrives within a programmable timeout, the attempt counts as a failure. A saturating counter records failed attempts, and the controller then waits for the receiver to report out-of-frame before it tries again. Once aligned, the controller does nothing until the receiver reports out-of-frame or a DIP-4 error. It never realigns on a timer. An alignment-complete pulse that arrives while no request is outstanding is ignored and sets a sticky error flag.

The states and their transitions are as follows:
- **IDLE_LOCKED**: goes to SETTLE when out-of-frame is high. Otherwise goes to WAIT_OOF on a DIP-4 error.
- **WAIT_OOF**: goes to SETTLE when out-of-frame is high.
- **SETTLE**: goes back to IDLE_LOCKED if out-of-frame drops. Goes to REQUEST when the settle delay ends.
- **REQUEST**: sends the pulse and goes to WAIT_DONE. If out-of-frame has dropped, goes to IDLE_LOCKED without a pulse.
- **WAIT_DONE**: goes to IDLE_LOCKED on alignment-complete. Goes to WAIT_OOF on timeout.

Top module: `rlac_realign_ctrl`

## Requirements
- R1: While reset is held, the outputs are: state_o = 0, align_req_o = 0, fail_cnt_o = 0 and stray_done_o = 0.
- R2: state_o encodes IDLE_LOCKED=0, WAIT_OOF=1, SETTLE=2, REQUEST=3 and WAIT_DONE=4. In IDLE_LOCKED, a high oof_i at a clock edge moves the state to SETTLE.
- R3: frame_pat_o equals oof_i in every cycle, so the framing pattern is selected exactly while the receiver is out of frame.
- R4: SETTLE lasts settle_cycles_i+1 cycles, after which the state moves to REQUEST. If oof_i is low at any edge during SETTLE, the state returns to IDLE_LOCKED and no request is issued.
- R5: align_req_o is high only in REQUEST with oof_i high. It lasts exactly one cycle, and the state then moves to WAIT_DONE.
- R6: An align_done_i pulse in WAIT_DONE returns the state to IDLE_LOCKED at the next edge.
- R7: If WAIT_DONE lasts timeout_cycles_i+1 cycles without align_done_i, the state moves to WAIT_OOF and fail_cnt_o increments. A retry follows only through SETTLE once oof_i is high.
- R8: fail_cnt_o saturates at 2^FAIL_W-1 and never wraps or decreases.
- R9: A dip_err_i pulse in IDLE_LOCKED with oof_i low moves the state to WAIT_OOF. No request follows until oof_i rises and the settle delay completes.
- R10: dip_err_i has no effect outside IDLE_LOCKED. In particular, it does not restart an attempt in WAIT_DONE.
- R11: align_done_i outside WAIT_DONE does not change the state and sets stray_done_o, which stays set until reset.
- R12: In IDLE_LOCKED with oof_i and dip_err_i both low, the state stays IDLE_LOCKED and no request is issued, however long this lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oof_i | input | 1 | Receiver out-of-frame flag |
| dip_err_i | input | 1 | DIP-4 parity error pulse |
| align_done_i | input | 1 | Alignment-complete pulse from the phase-alignment logic |
| settle_cycles_i | input | CNT_W | Settle delay minus one, in cycles |
| timeout_cycles_i | input | CNT_W | Alignment timeout minus one, in cycles |
| align_req_o | output | 1 | Single-cycle alignment request |
| frame_pat_o | output | 1 | Selects the all-11 framing pattern on the status channel |
| state_o | output | 3 | Controller state code |
| fail_cnt_o | output | FAIL_W | Saturating count of failed attempts |
| stray_done_o | output | 1 | Sticky flag for an unexpected alignment-complete |

## Verification
Directed runs separate four cases:
- A clean out-of-frame that runs through settle, request and completion.
- An out-of-frame that clears during settle and so must produce no request.
- A timed-out attempt that must fall back to WAIT_OOF and retry only via SETTLE.
- A parity error while locked, which must wait for out-of-frame before it acts.

Further cases test that a parity error during WAIT_DONE does not restart the attempt, that completion arriving while idle leaves the state alone and sets the sticky flag, and that repeated timeouts saturate the failure count. Random runs then toggle out-of-frame, parity and completion pulses, with settle and timeout values that change between segments. These runs expose off-by-one errors in either counter and priority errors between simultaneous inputs.

// File: rtl/rlac_pkg.sv
package rlac_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_LOCKED = 3'd0,
        ST_WAIT_OOF    = 3'd1,
        ST_SETTLE      = 3'd2,
        ST_REQUEST     = 3'd3,
        ST_WAIT_DONE   = 3'd4
    } rlac_state_e;

endpackage

// File: rtl/rlac_cycle_timer.sv
// Counts cycles while run_i is high and reports when the limit is reached.
// The count returns to zero in any cycle with run_i low.
module rlac_cycle_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q < limit_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = run_i && (cnt_q >= limit_i);

endmodule

// File: rtl/rlac_sat_counter.sv
// Counts increments and holds at the maximum value instead of wrapping.
module rlac_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != MAXV)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;

    AST_SAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV) |=> (cnt_q == MAXV)); // R8

    AST_SAT_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q >= $past(cnt_q))); // R8

endmodule

// File: rtl/rlac_realign_ctrl.sv
module rlac_realign_ctrl
    import rlac_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int FAIL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oof_i,
    input  logic              dip_err_i,
    input  logic              align_done_i,
    input  logic [CNT_W-1:0]  settle_cycles_i,
    input  logic [CNT_W-1:0]  timeout_cycles_i,
    output logic              align_req_o,
    output logic              frame_pat_o,
    output logic [2:0]        state_o,
    output logic [FAIL_W-1:0] fail_cnt_o,
    output logic              stray_done_o
);

    rlac_state_e state_q, state_d;
    logic        settle_done;
    logic        wait_expired;
    logic        fail_inc;
    logic        stray_q;

    // Settle delay: counts while in SETTLE.
    rlac_cycle_timer #(.W(CNT_W)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_SETTLE),
        .limit_i   (settle_cycles_i),
        .expired_o (settle_done)
    );

    // Alignment timeout: counts while in WAIT_DONE.
    rlac_cycle_timer #(.W(CNT_W)) u_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_WAIT_DONE),
        .limit_i   (timeout_cycles_i),
        .expired_o (wait_expired)
    );

    rlac_sat_counter #(.W(FAIL_W)) u_fails (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (fail_inc),
        .count_o (fail_cnt_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        fail_inc = 1'b0;
        unique case (state_q)
            ST_IDLE_LOCKED: begin
                if (oof_i) begin
                    state_d = ST_SETTLE;
                end else if (dip_err_i) begin
                    state_d = ST_WAIT_OOF;
                end
            end
            ST_WAIT_OOF: begin
                if (oof_i) begin
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (!oof_i) begin
                    state_d = ST_IDLE_LOCKED;
                end else if (settle_done) begin
                    state_d = ST_REQUEST;
                end
            end
            ST_REQUEST: begin
                state_d = oof_i ? ST_WAIT_DONE : ST_IDLE_LOCKED;
            end
            ST_WAIT_DONE: begin
                if (align_done_i) begin
                    state_d = ST_IDLE_LOCKED;
                end else if (wait_expired) begin
                    state_d  = ST_WAIT_OOF;
                    fail_inc = 1'b1;
                end
            end
            default: state_d = ST_IDLE_LOCKED;
        endcase
    end

    // Output logic
    always_comb begin
        align_req_o  = (state_q == ST_REQUEST) && oof_i;
        frame_pat_o  = oof_i;
        state_o      = state_q;
        stray_done_o = stray_q;
    end

    // Sticky flag: alignment-complete arrived while no request was outstanding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stray_q <= 1'b0;
        end else if (align_done_i && (state_q != ST_WAIT_DONE)) begin
            stray_q <= 1'b1;
        end
    end

    AST_REQ_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        align_req_o |-> ($past(state_q) == ST_SETTLE)); // R4

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        align_req_o |=> !align_req_o); // R5

    AST_FAIL_ONLY_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_cnt_o != $past(fail_cnt_o)) |-> ($past(state_q) == ST_WAIT_DONE)); // R7

    AST_DIP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_DONE && dip_err_i && !align_done_i && !wait_expired)
        |=> (state_q == ST_WAIT_DONE)); // R10

    AST_STRAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stray_done_o |=> stray_done_o); // R11

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE_LOCKED && !oof_i && !dip_err_i)
        |=> (state_q == ST_IDLE_LOCKED)); // R12

endmodule

// File: tb/sim_rlac_realign_ctrl.sv
`timescale 1ns/1ps
module sim_rlac_realign_ctrl;

    localparam int CW = 8;
    localparam int FW = 3;
    localparam int FMAX = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          oof = 1'b0, dip = 1'b0, done = 1'b0;
    logic [CW-1:0] settle = 8'd2, tmo = 8'd3;
    logic          req, fpat, stray;
    logic [2:0]    st;
    logic [FW-1:0] fails;

    int n_chk = 0, n_bad = 0, wd = 0;

    // Reference model state
    int e_st = 0, e_sc = 0, e_tc = 0, e_fail = 0, e_stray = 0;

    always #2.5 clk = ~clk;

    rlac_realign_ctrl #(.CNT_W(CW), .FAIL_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .oof_i(oof), .dip_err_i(dip),
        .align_done_i(done), .settle_cycles_i(settle), .timeout_cycles_i(tmo),
        .align_req_o(req), .frame_pat_o(fpat), .state_o(st),
        .fail_cnt_o(fails), .stray_done_o(stray)
    );

    function automatic int next_state(int s, int sc, int tc);
        case (s)
            0: return oof ? 2 : (dip ? 1 : 0);
            1: return oof ? 2 : 1;
            2: return !oof ? 0 : ((sc >= int'(settle)) ? 3 : 2);
            3: return oof ? 4 : 0;
            4: return done ? 0 : ((tc >= int'(tmo)) ? 1 : 4);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_st = 0; e_sc = 0; e_tc = 0; e_fail = 0; e_stray = 0;
        end else begin
            int ns;
            ns = next_state(e_st, e_sc, e_tc);
            if (done && e_st != 4) e_stray = 1;
            if (e_st == 4 && ns == 1 && e_fail < FMAX) e_fail = e_fail + 1;
            e_sc = (e_st == 2) ? ((e_sc < int'(settle)) ? e_sc + 1 : e_sc) : 0;
            e_tc = (e_st == 4) ? ((e_tc < int'(tmo)) ? e_tc + 1 : e_tc) : 0;
            e_st = ns;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        check("R2 state", int'(st), e_st);
        check("R5 request", int'(req), (e_st == 3 && oof) ? 1 : 0);
        check("R3 framing", int'(fpat), int'(oof));
        check("R8 fail count", int'(fails), e_fail);
        check("R11 stray", int'(stray), e_stray);
    endtask

    task automatic cyc(input logic o, input logic d, input logic c);
        @(negedge clk);
        oof = o; dip = d; done = c;
        #0.5;
        cmp_all();
    endtask

    task automatic go_state(int s, input logic o);
        for (int i = 0; i < 100 && int'(st) != s; i++) cyc(o, 1'b0, 1'b0);
    endtask

    task automatic to_locked();
        go_state(4, 1'b1);
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", wd);
            summary();
        end
    end

    initial begin
        // R1 reset values
        #7;
        check("R1 state", int'(st), 0);
        check("R1 request", int'(req), 0);
        check("R1 fail count", int'(fails), 0);
        check("R1 stray", int'(stray), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2 / R4: settle of settle+1 cycles, then one request pulse
        cyc(1'b1, 1'b0, 1'b0);
        check("R2 idle before edge", int'(st), 0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 1'b0);
            check("R4 settling", int'(st), 2);
            check("R4 no early request", int'(req), 0);
        end
        cyc(1'b1, 1'b0, 1'b0);
        check("R4 request after settle", int'(req), 1);
        cyc(1'b1, 1'b0, 1'b0);
        check("R5 pulse ends", int'(req), 0);
        check("R5 waiting", int'(st), 4);
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        check("R6 locked after done", int'(st), 0);

        // R4: out-of-frame clears during settle
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        check("R4 abort to idle", int'(st), 0);
        check("R4 no request", int'(req), 0);

        // R7: timeout, failure, retry through settle
        go_state(4, 1'b1);
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0);
        check("R7 timeout to wait_oof", int'(st), 1);
        check("R7 fail increments", int'(fails), 1);
        cyc(1'b1, 1'b0, 1'b0);
        check("R7 retry via settle", int'(st), 2);
        to_locked();

        // R10: parity error during WAIT_DONE ignored
        go_state(4, 1'b1);
        cyc(1'b1, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        check("R10 dip ignored", int'(st), 4);
        cyc(1'b1, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);

        // R9: parity error while locked waits for out-of-frame
        cyc(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) begin
            cyc(1'b0, 1'b0, 1'b0);
            check("R9 waiting for oof", int'(st), 1);
            check("R9 no request", int'(req), 0);
        end
        cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0);
        check("R9 settle after oof", int'(st), 2);
        to_locked();

        // R12: long quiet lock
        for (int i = 0; i < 50; i++) begin
            cyc(1'b0, 1'b0, 1'b0);
            check("R12 stays locked", int'(st), 0);
        end

        // R11: stray completion
        check("R11 clear before", int'(stray), 0);
        cyc(1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0);
        check("R11 stray set", int'(stray), 1);
        check("R11 state unchanged", int'(st), 0);

        // R8: saturation after repeated timeouts
        tmo = 8'd0;
        settle = 8'd0;
        for (int k = 0; k < 9; k++) begin
            go_state(4, 1'b1);
            go_state(1, 1'b1);
        end
        check("R8 saturated", int'(fails), FMAX);
        to_locked();

        // Random segments
        void'($urandom(32'h5eed_1234));
        for (int seg = 0; seg < 15; seg++) begin
            settle = 8'($urandom_range(0, 5));
            tmo    = 8'($urandom_range(0, 6));
            for (int i = 0; i < 200; i++) begin
                logic o;
                o = ($urandom_range(0, 7) == 0) ? ~oof : oof;
                cyc(o, $urandom_range(0, 15) == 0, $urandom_range(0, 4) == 0);
            end
        end
        summary();
    end

endmodule